// File: doc/BRIEF.md
# Striped Sector Test Pattern Engine

This block drives a 512-bit-per-cycle test stream into a write FIFO and verifies a 512-bit stream drained from a read FIFO. Both directions share one pattern generator. The generator is primed by a start pulse with a start sector address and a pattern code. Every 512-byte sector (8 beats) of the increment, decrement and LFSR patterns opens with a 64-bit header that carries the sector address. A storage back-end can therefore be checked for both data integrity and sector placement.

In write mode the start pulse arms a transfer of a programmed number of beats. Each beat is pushed only while the write FIFO has room. In read mode the block pulls a beat whenever the read FIFO holds data, with no start gating and no count limit. Each received beat is compared one cycle later against the expected word. The first mismatch latches a sticky fail flag, the failing byte address, and both 512-bit words.

Top module: `sector_pattern_engine`

## Requirements
- R1: After reset both FIFO enables are low, the fail flag is 0, the captured failure fields are 0 and the byte count is 0.
- R2: A start pulse is accepted only when no write transfer is active. An accepted pulse latches the start sector address, the pattern code and the beat count, restarts the beat counter, clears the fail state and reseeds the generator. A pulse that arrives during an active transfer has no effect. A beat count of zero starts no transfer.
- R3: An accepted start in write mode (mode input 0) with a nonzero beat count raises the active state on the next clock. Write enable is high exactly when that state is active and almost-full is low. After the programmed number of beats have been written, active and write enable fall in the same cycle.
- R4: Read enable is high exactly when the mode input is 1 (read) and the read FIFO is not empty, independent of start and count.
- R5: The byte count output equals 64 times the number of beats written or read since the last accepted start, and rises by 64 on each accepted beat.
- R6: Pattern codes are 000 increment, 001 decrement, 010 all zeros, 011 all ones, 100 LFSR; 101, 110 and 111 give all zeros. In the increment pattern, dword k (bits 32k+31..32k) of beat n is (16n+k) mod 2^32. The decrement pattern is its bitwise inverse.
- R7: In the LFSR pattern, dword 4L+j of beat n holds state 4n+j+1 of lane L. The lane starts from its seed, and one step shifts the 32-bit state left by one and puts bit30 xor bit20 xor bit0 into bit 0. With start sector A the lane seeds are: lane 0 A, lane 1 ~A, lane 2 {A[15:0], ~A[31:16]}, lane 3 {~A[15:0], A[31:16]}.
- R8: For codes 000, 001 and 100, a beat n with n mod 8 = 0 has dword 0 replaced by the sector address S = A + n/8 and dword 1 replaced by ~S. The all-zeros and all-ones patterns carry no header.
- R9: The word read on beat n is compared with expected beat n in the cycle after its read enable. On a mismatch the fail flag sets and stays set until the next accepted start. Only the first mismatch captures byte address 64n, the expected word and the received word; later mismatches leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| mode_rd_i | input | 1 | 0 write mode, 1 read mode |
| xfer_beats_i | input | CNT_W | Write transfer length in 512-bit beats |
| start_sector_i | input | 32 | Start sector address |
| patt_sel_i | input | 3 | Pattern code |
| wr_afull_i | input | 1 | Write FIFO almost full |
| fifo_wr_en_o | output | 1 | Write FIFO write enable |
| fifo_wr_data_o | output | DATA_W | Write FIFO data |
| rd_empty_i | input | 1 | Read FIFO empty |
| fifo_rd_en_o | output | 1 | Read FIFO read enable |
| rd_data_i | input | DATA_W | Read FIFO data, valid one cycle after read enable |
| fail_o | output | 1 | Sticky verification failure |
| fail_byte_addr_o | output | CNT_W+6 | Byte address of first failing beat |
| fail_exp_o | output | DATA_W | Expected word at first failure |
| fail_got_o | output | DATA_W | Received word at first failure |
| byte_cnt_o | output | CNT_W+6 | Running byte count |

## Verification
In read mode, the compare of the previous beat and the acceptance of a new beat fall in the same cycle whenever the read FIFO stays non-empty. The generator advances while the registered expected word is still being judged. The bench provokes this by loading two consecutive corrupted beats and draining them back-to-back. It checks that the captured address, expected word and received word belong to the first corrupted beat. In write mode, the last beat of a sector coincides with the sector address step, and the last beat of a transfer can coincide with almost-full toggling. Both are judged by the per-cycle reference model of header contents and stop timing.

// File: rtl/sector_pattern_pkg.sv
// Shared constants, pattern codes and LFSR helpers for the sector pattern engine.
package sector_pattern_pkg;
    localparam int DW           = 32;   // dword width
    localparam int SEC_W        = 32;   // sector address width
    localparam int LANE_DW      = 4;    // dwords produced per LFSR lane per beat
    localparam int SECTOR_BYTES = 512;

    typedef enum logic [2:0] {
        PAT_INC  = 3'b000,
        PAT_DEC  = 3'b001,
        PAT_ZERO = 3'b010,
        PAT_ONE  = 3'b011,
        PAT_LFSR = 3'b100
    } patt_e;

    // One step of the 32-bit shift register, taps for x^31 + x^21 + x + 1.
    function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] s);
        return {s[DW-2:0], s[30] ^ s[20] ^ s[0]};
    endfunction

    // Seed of one lane, mixed from the sector address and its inverse.
    function automatic logic [DW-1:0] lane_seed(input logic [SEC_W-1:0] a, input logic [1:0] lane);
        logic [DW-1:0] r;
        case (lane)
            2'd0:    r = a;
            2'd1:    r = ~a;
            2'd2:    r = {a[15:0], ~a[31:16]};
            default: r = {~a[15:0], a[31:16]};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/spe_ctrl.sv
// Transfer control: accepts start pulses, holds the write-active state,
// gates both FIFO enables and counts accepted beats.
// Assumes start_i is a single-cycle pulse and the mode input is stable during a run.
module spe_ctrl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_rd_i,
    input  logic [CNT_W-1:0] xfer_beats_i,
    input  logic             wr_afull_i,
    input  logic             rd_empty_i,
    output logic             load_o,
    output logic             wr_en_o,
    output logic             rd_en_o,
    output logic [CNT_W-1:0] beat_cnt_o
);
    logic             active_q;
    logic [CNT_W-1:0] end_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_beat;

    // Enables and the start-acceptance decision.
    always_comb begin
        load_o    = start_i & ~active_q;
        wr_en_o   = active_q & ~wr_afull_i;
        rd_en_o   = mode_rd_i & ~rd_empty_i;
        last_beat = wr_en_o && ((cnt_q + CNT_W'(1)) == end_q);
    end

    // Write-active state and latched transfer length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            end_q    <= '0;
        end else if (load_o) begin
            active_q <= ~mode_rd_i & (|xfer_beats_i);
            end_q    <= xfer_beats_i;
        end else if (last_beat) begin
            active_q <= 1'b0;
        end
    end

    // Beat counter shared by both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load_o)             cnt_q <= '0;
        else if (wr_en_o | rd_en_o)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign beat_cnt_o = cnt_q;
endmodule

// File: rtl/spe_gen.sv
// Pattern generator: builds the 512-bit word for the current beat from the
// beat counter, the sector address counter and per-lane LFSR states.
// Assumes DATA_W is a multiple of 128 and adv_i marks every accepted beat.
module spe_gen
    import sector_pattern_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [SEC_W-1:0]  start_sector_i,
    input  logic [2:0]        patt_sel_i,
    input  logic [CNT_W-1:0]  beat_cnt_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int N_DW    = DATA_W / DW;
    localparam int NDW_LOG = $clog2(N_DW);
    localparam int LANES   = N_DW / LANE_DW;
    localparam int SB_W    = $clog2(SECTOR_BYTES * 8 / DATA_W);

    logic [SEC_W-1:0]  sector_q;
    logic [2:0]        sel_q;
    logic [DW-1:0]     inc_base;
    logic [DATA_W-1:0] inc_word;
    logic [DATA_W-1:0] lfsr_word;
    logic [DATA_W-1:0] body;
    logic              sector_first;
    logic              sector_last;

    assign sector_first = (beat_cnt_i[SB_W-1:0] == '0);
    assign sector_last  = &beat_cnt_i[SB_W-1:0];

    // Sector address counter and latched pattern code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sector_q <= '0;
            sel_q    <= PAT_INC;
        end else if (load_i) begin
            sector_q <= start_sector_i;
            sel_q    <= patt_sel_i;
        end else if (adv_i && sector_last) begin
            sector_q <= sector_q + SEC_W'(1);
        end
    end

    // Incrementing dwords derived from the beat counter.
    assign inc_base = DW'({beat_cnt_i, {NDW_LOG{1'b0}}});
    for (genvar k = 0; k < N_DW; k++) begin : g_inc
        assign inc_word[k*DW +: DW] = inc_base + DW'(k);
    end

    // LFSR lanes, each stepping LANE_DW states per beat by look-ahead.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DW-1:0] state_q;
        logic [DW-1:0] la [LANE_DW+1];

        // Look-ahead chain of successive states.
        always_comb begin
            la[0] = state_q;
            for (int j = 0; j < LANE_DW; j++) la[j+1] = lfsr_step(la[j]);
        end

        for (genvar j = 0; j < LANE_DW; j++) begin : g_dw
            assign lfsr_word[(l*LANE_DW + j)*DW +: DW] = la[j+1];
        end

        // Lane state: reseed on load, advance on each accepted beat.
        always_ff @(posedge clk) begin
            if (!rst_n)      state_q <= lane_seed('0, 2'(l));
            else if (load_i) state_q <= lane_seed(start_sector_i, 2'(l));
            else if (adv_i)  state_q <= la[LANE_DW];
        end
    end

    // Pattern selection and header insertion.
    always_comb begin
        case (sel_q)
            PAT_INC:  body = inc_word;
            PAT_DEC:  body = ~inc_word;
            PAT_ONE:  body = '1;
            PAT_LFSR: body = lfsr_word;
            default:  body = '0;
        endcase
        word_o = body;
        if (sector_first && (sel_q == PAT_INC || sel_q == PAT_DEC || sel_q == PAT_LFSR))
            word_o[2*DW-1:0] = {~sector_q, sector_q};
    end
endmodule

// File: rtl/spe_cmp.sv
// Read checker: registers the expected word with each read enable, compares
// it with the FIFO data one cycle later and captures the first failure.
// Assumes the read FIFO returns data exactly one cycle after its read enable.
module spe_cmp #(
    parameter int DATA_W = 512,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [CNT_W-1:0]  beat_cnt_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              fail_o,
    output logic [CNT_W-1:0]  fail_beat_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_got_o
);
    logic              pend_q;
    logic [DATA_W-1:0] exp_q;
    logic [CNT_W-1:0]  idx_q;
    logic              mismatch;

    assign mismatch = pend_q && (rd_data_i != exp_q);

    // Expected word and beat index held for the next-cycle compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            exp_q  <= '0;
            idx_q  <= '0;
        end else begin
            pend_q <= rd_en_i;
            if (rd_en_i) begin
                exp_q <= exp_i;
                idx_q <= beat_cnt_i;
            end
        end
    end

    // Sticky fail flag and first-failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            fail_o      <= 1'b0;
            fail_beat_o <= '0;
            fail_exp_o  <= '0;
            fail_got_o  <= '0;
        end else if (mismatch && !fail_o) begin
            fail_o      <= 1'b1;
            fail_beat_o <= idx_q;
            fail_exp_o  <= exp_q;
            fail_got_o  <= rd_data_i;
        end
    end
endmodule

// File: rtl/sector_pattern_engine.sv
// Top level: test stream generator and checker for a striped sector store.
// Write mode pushes a counted pattern stream; read mode drains and verifies.
// Assumes FIFOs outside with almost-full / empty flags and one-cycle read latency.
module sector_pattern_engine
    import sector_pattern_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int CNT_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 mode_rd_i,
    input  logic [CNT_W-1:0]     xfer_beats_i,
    input  logic [SEC_W-1:0]     start_sector_i,
    input  logic [2:0]           patt_sel_i,
    input  logic                 wr_afull_i,
    output logic                 fifo_wr_en_o,
    output logic [DATA_W-1:0]    fifo_wr_data_o,
    input  logic                 rd_empty_i,
    output logic                 fifo_rd_en_o,
    input  logic [DATA_W-1:0]    rd_data_i,
    output logic                 fail_o,
    output logic [CNT_W+5:0]     fail_byte_addr_o,
    output logic [DATA_W-1:0]    fail_exp_o,
    output logic [DATA_W-1:0]    fail_got_o,
    output logic [CNT_W+5:0]     byte_cnt_o
);
    localparam int BEAT_LOG = $clog2(DATA_W / 8);

    logic              load;
    logic              adv;
    logic [CNT_W-1:0]  beat_cnt;
    logic [CNT_W-1:0]  fail_beat;
    logic [DATA_W-1:0] gen_word;

    assign adv = fifo_wr_en_o | fifo_rd_en_o;

    spe_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_rd_i    (mode_rd_i),
        .xfer_beats_i (xfer_beats_i),
        .wr_afull_i   (wr_afull_i),
        .rd_empty_i   (rd_empty_i),
        .load_o       (load),
        .wr_en_o      (fifo_wr_en_o),
        .rd_en_o      (fifo_rd_en_o),
        .beat_cnt_o   (beat_cnt)
    );

    spe_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_i         (load),
        .adv_i          (adv),
        .start_sector_i (start_sector_i),
        .patt_sel_i     (patt_sel_i),
        .beat_cnt_i     (beat_cnt),
        .word_o         (gen_word)
    );

    spe_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (load),
        .rd_en_i     (fifo_rd_en_o),
        .exp_i       (gen_word),
        .beat_cnt_i  (beat_cnt),
        .rd_data_i   (rd_data_i),
        .fail_o      (fail_o),
        .fail_beat_o (fail_beat),
        .fail_exp_o  (fail_exp_o),
        .fail_got_o  (fail_got_o)
    );

    assign fifo_wr_data_o   = gen_word;
    assign byte_cnt_o       = {beat_cnt, {BEAT_LOG{1'b0}}};
    assign fail_byte_addr_o = {fail_beat, {BEAT_LOG{1'b0}}};
endmodule

// File: rtl/sector_pattern_engine_sva.sv
// Port-level properties of the sector pattern engine, bound to the top.
module sector_pattern_engine_sva #(
    parameter int DATA_W = 512,
    parameter int CNT_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mode_rd_i,
    input logic             wr_afull_i,
    input logic             rd_empty_i,
    input logic             fifo_wr_en_o,
    input logic             fifo_rd_en_o,
    input logic             fail_o,
    input logic [CNT_W+5:0] fail_byte_addr_o,
    input logic [CNT_W+5:0] byte_cnt_o
);
    localparam int BYTE_W = CNT_W + 6;
    localparam int BEAT_B = DATA_W / 8;

    // R3: no write while the FIFO reports almost full
    a_r3_wr_room: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en_o |-> !wr_afull_i);

    // R4: reads only in read mode with data present
    a_r4_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en_o |-> (mode_rd_i && !rd_empty_i));

    // R5: each accepted beat adds one beat of bytes
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && (fifo_wr_en_o || fifo_rd_en_o)) |=> byte_cnt_o == $past(byte_cnt_o) + BYTE_W'(BEAT_B));

    // R5: count holds without traffic or start
    a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !fifo_wr_en_o && !fifo_rd_en_o) |=> $stable(byte_cnt_o));

    // R9: fail flag stays set until a start
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);

    // R9: captured address is not overwritten by later mismatches
    a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> $stable(fail_byte_addr_o));
endmodule

bind sector_pattern_engine sector_pattern_engine_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_sva (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .mode_rd_i        (mode_rd_i),
    .wr_afull_i       (wr_afull_i),
    .rd_empty_i       (rd_empty_i),
    .fifo_wr_en_o     (fifo_wr_en_o),
    .fifo_rd_en_o     (fifo_rd_en_o),
    .fail_o           (fail_o),
    .fail_byte_addr_o (fail_byte_addr_o),
    .byte_cnt_o       (byte_cnt_o)
);

// File: tb/test_sector_pattern_engine.sv
`timescale 1ns/100ps
module test_sector_pattern_engine;
    localparam int DATA_W = 512;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              mode_rd_i = 1'b0;
    logic [CNT_W-1:0]  xfer_beats_i = '0;
    logic [31:0]       start_sector_i = '0;
    logic [2:0]        patt_sel_i = '0;
    logic              wr_afull_i = 1'b0;
    logic              rd_empty_i = 1'b1;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              fifo_wr_en_o, fifo_rd_en_o, fail_o;
    logic [DATA_W-1:0] fifo_wr_data_o, fail_exp_o, fail_got_o;
    logic [CNT_W+5:0]  fail_byte_addr_o, byte_cnt_o;

    sector_pattern_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_sector_pattern_engine (.*);

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0, n_fail = 0, cyc = 0;
    string ph = "";
    bit afull_on = 0, gap_on = 0, rd_hold = 1;
    logic [DATA_W-1:0] fq [$];

    // reference model state
    bit          m_active, m_fail, m_pend;
    longint      m_cnt, m_end, m_pidx, m_faddr;
    logic [31:0] m_start;
    logic [2:0]  m_sel;
    logic [DATA_W-1:0] m_fexp, m_fgot;

    task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_seed(input int lane);
        case (lane)
            0: return m_start;
            1: return ~m_start;
            2: return {m_start[15:0], ~m_start[31:16]};
            default: return {~m_start[15:0], m_start[31:16]};
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ref_word(input longint n);
        logic [DATA_W-1:0] w;
        logic [31:0] s, sec;
        for (int k = 0; k < 16; k++) begin
            case (m_sel)
                3'd0: w[k*32 +: 32] = 32'(n*16 + k);
                3'd1: w[k*32 +: 32] = ~32'(n*16 + k);
                3'd3: w[k*32 +: 32] = '1;
                3'd4: begin
                    s = ref_seed(k/4);
                    for (longint t = 0; t < 4*n + (k%4) + 1; t++) s = {s[30:0], s[30] ^ s[20] ^ s[0]};
                    w[k*32 +: 32] = s;
                end
                default: w[k*32 +: 32] = '0;
            endcase
        end
        if ((m_sel == 3'd0 || m_sel == 3'd1 || m_sel == 3'd4) && (n % 8 == 0)) begin
            sec = m_start + 32'(n/8);
            w[31:0]  = sec;
            w[63:32] = ~sec;
        end
        return w;
    endfunction

    // bench FIFO and flow-control stimulus
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fifo_rd_en_o) rd_data_i <= fq.pop_front();
    end
    always @(posedge clk) begin
        #1;
        rd_empty_i = rd_hold || (fq.size() == 0) || (gap_on && (cyc % 5 == 3));
        wr_afull_i = afull_on && ((cyc % 7 == 2) || (cyc % 7 == 3));
    end

    // per-cycle reference model and comparison
    always @(negedge clk) begin
        bit exp_wr, exp_rd, ld;
        string dtag;
        if (!rst_n) begin
            m_active = 0; m_fail = 0; m_pend = 0; m_cnt = 0; m_end = 0; m_pidx = 0;
            m_faddr = 0; m_start = 0; m_sel = 0; m_fexp = '0; m_fgot = '0;
        end else begin
            exp_wr = m_active && !wr_afull_i;
            exp_rd = mode_rd_i && !rd_empty_i;
            chk(fifo_wr_en_o == exp_wr, {"R3 ", ph}, DATA_W'(fifo_wr_en_o), DATA_W'(exp_wr));
            chk(fifo_rd_en_o == exp_rd, {"R4 ", ph}, DATA_W'(fifo_rd_en_o), DATA_W'(exp_rd));
            chk(byte_cnt_o == (CNT_W+6)'(m_cnt*64), {"R5 ", ph}, DATA_W'(byte_cnt_o), DATA_W'(m_cnt*64));
            chk(fail_o == m_fail, {"R9 ", ph}, DATA_W'(fail_o), DATA_W'(m_fail));
            if (m_fail) begin
                chk(fail_byte_addr_o == (CNT_W+6)'(m_faddr), "R9 addr", DATA_W'(fail_byte_addr_o), DATA_W'(m_faddr));
                chk(fail_exp_o == m_fexp, "R9 exp", fail_exp_o, m_fexp);
                chk(fail_got_o == m_fgot, "R9 got", fail_got_o, m_fgot);
            end
            if (exp_wr) begin
                dtag = (m_sel == 3'd4) ? "R7" : "R6";
                if (m_cnt % 8 == 0) dtag = {dtag, " R8"};
                chk(fifo_wr_data_o == ref_word(m_cnt), {dtag, " ", ph}, fifo_wr_data_o, ref_word(m_cnt));
            end
            // next state as seen after the coming edge
            if (m_pend && !m_fail && (rd_data_i != ref_word(m_pidx))) begin
                m_fail = 1; m_faddr = m_pidx*64; m_fexp = ref_word(m_pidx); m_fgot = rd_data_i;
            end
            ld = start_i && !m_active;
            if (ld) begin
                m_cnt = 0; m_fail = 0; m_faddr = 0; m_fexp = '0; m_fgot = '0;
                m_start = start_sector_i; m_sel = patt_sel_i; m_end = xfer_beats_i;
                m_active = !mode_rd_i && (xfer_beats_i != 0);
            end else begin
                if (exp_wr) begin
                    m_cnt++;
                    if (m_cnt == m_end) m_active = 0;
                end
                if (exp_rd) begin
                    m_pidx = m_cnt;
                    m_cnt++;
                end
            end
            m_pend = exp_rd;
        end
    end

    task automatic go(input bit rd, input int unsigned beats, input logic [31:0] a, input logic [2:0] s);
        @(posedge clk); #0.5;
        mode_rd_i = rd; xfer_beats_i = beats; start_sector_i = a; patt_sel_i = s; start_i = 1'b1;
        @(posedge clk); #0.5;
        start_i = 1'b0;
    endtask

    task automatic wait_write;
        @(posedge clk);
        while (m_active) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic drain;
        #0.5 rd_hold = 0;
        while (fq.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #0.5 rd_hold = 1; gap_on = 0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) if (cyc > 50000) begin
        n_fail++;
        $display("FAIL watchdog R3 actual=%0d expected=<50000", cyc);
        summary();
    end

    initial begin
        logic [DATA_W-1:0] flip;
        flip = {16{32'h0000_0100}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!fifo_wr_en_o && !fifo_rd_en_o, "R1 enables", DATA_W'({fifo_wr_en_o, fifo_rd_en_o}), '0);
        chk(!fail_o && byte_cnt_o == 0 && fail_byte_addr_o == 0, "R1 status", DATA_W'(byte_cnt_o), '0);
        chk(fail_exp_o == 0 && fail_got_o == 0, "R1 capture", fail_exp_o | fail_got_o, '0);
        @(posedge clk); #0.5 rst_n = 1'b1;

        // increment pattern, almost-full pauses, ignored restart
        ph = "inc"; afull_on = 1;
        go(0, 20, 32'd5, 3'b000);
        repeat (5) @(posedge clk);
        #0.5 ph = "R2 ignored start"; start_sector_i = 32'd999; patt_sel_i = 3'b011; start_i = 1'b1;
        @(posedge clk); #0.5 start_i = 1'b0;
        wait_write();
        chk(byte_cnt_o == 20*64, "R3 end size", DATA_W'(byte_cnt_o), DATA_W'(20*64));

        // decrement, constant patterns, reserved code
        afull_on = 0; ph = "dec";
        go(0, 9, 32'd8, 3'b001);  wait_write();
        ph = "zero"; go(0, 3, 32'd1, 3'b010); wait_write();
        ph = "ones"; go(0, 3, 32'd1, 3'b011); wait_write();
        ph = "reserved"; go(0, 2, 32'd1, 3'b110); wait_write();

        // LFSR with pauses
        afull_on = 1; ph = "lfsr";
        go(0, 17, 32'hA5A5_0F0F, 3'b100); wait_write();
        afull_on = 0;

        // zero length: no transfer
        ph = "R2 zero size";
        go(0, 0, 32'd3, 3'b000);
        repeat (5) @(posedge clk);
        chk(byte_cnt_o == 0 && !fifo_wr_en_o, "R2 zero size", DATA_W'(byte_cnt_o), '0);

        // clean LFSR read-back with gaps
        ph = "read lfsr";
        go(1, 0, 32'd100, 3'b100);
        for (int i = 0; i < 24; i++) fq.push_back(ref_word(i));
        gap_on = 1;
        drain();
        chk(!fail_o && byte_cnt_o == 24*64, "R9 clean read", DATA_W'(byte_cnt_o), DATA_W'(24*64));

        // back-to-back corrupted beats: first capture must win
        ph = "read corrupt";
        go(1, 0, 32'd7, 3'b000);
        for (int i = 0; i < 20; i++) fq.push_back((i == 11 || i == 12) ? (ref_word(i) ^ flip) : ref_word(i));
        drain();
        chk(fail_o == 1'b1, "R9 sticky", DATA_W'(fail_o), DATA_W'(1));
        chk(fail_byte_addr_o == 11*64, "R9 first addr", DATA_W'(fail_byte_addr_o), DATA_W'(11*64));
        chk(fail_exp_o == ref_word(11), "R9 first exp", fail_exp_o, ref_word(11));
        chk(fail_got_o == (ref_word(11) ^ flip), "R9 first got", fail_got_o, ref_word(11) ^ flip);

        // new start clears failure, decrement read-back
        ph = "read restart";
        go(1, 0, 32'd3, 3'b001);
        repeat (2) @(posedge clk);
        chk(!fail_o, "R2 fail cleared", DATA_W'(fail_o), '0);
        for (int i = 0; i < 10; i++) fq.push_back(ref_word(i));
        drain();
        chk(!fail_o && byte_cnt_o == 10*64, "R4 read count", DATA_W'(byte_cnt_o), DATA_W'(10*64));

        summary();
    end
endmodule